// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides when the clocks of a small 8051-family CPU subsystem run. It holds one byte-wide control register on the special function register bus. Two of its bits select a low-power state.

In the idle state only the CPU clock stops. The peripheral clock and the oscillator keep running, and any enabled interrupt returns the CPU to normal running. In the power-down state the CPU clock, the peripheral clock and the oscillator enable all drop. Interrupts and register writes are then ignored, and only a reset brings the subsystem back.

The block also makes the system reset. A qualified external reset produces it, and so does an internal request, which gives a reset of fixed length. Both lengths are counted in machine cycles of twelve oscillator clocks. The block's own counting logic runs on the free-running oscillator input, so it can restart the oscillator enable as soon as a reset cause arrives during power-down. The other six register bits are stored unchanged for neighbouring blocks. A low-voltage-detect enable output is held on at all times.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_i` is high, `sys_rst_o` is 1. After `rst_i` is released, `ctl_reg_o` reads 0x00, `mode_o` reads RUN (encoded 0), and `cpu_clk_en_o`, `per_clk_en_o` and `osc_en_o` are all 1.
- R2: A write with `sfr_wr_i`=1 and `sfr_addr_i` equal to `REG_ADDR` (default 0x87) loads the whole byte into the register, visible on `ctl_reg_o` after that clock edge. Writes to any other address leave the register unchanged.
- R3: Register bit 0 is the idle bit. One edge after it reads 1, `mode_o` is IDLE (encoded 1), `cpu_clk_en_o` is 0, and `per_clk_en_o` and `osc_en_o` are 1.
- R4: When `irq_i` is sampled high while bit 0 is set and no register write hits in that cycle, hardware clears bit 0 at that edge and leaves bits 7:1 unchanged. One edge later `mode_o` returns to RUN and `cpu_clk_en_o` to 1.
- R5: Register bit 1 is the power-down bit. A write with bit 1 set stores bit 0 as 0 (power-down wins over idle). One edge after bit 1 reads 1, `mode_o` is PDOWN (encoded 2) and all three clock enables are 0.
- R6: While bit 1 is set, `irq_i` and register writes leave the register and `mode_o` unchanged.
- R7: `sys_rst_o` rises at the edge where `ext_rst_i` has been sampled high on `EXT_RST_MC*CLKS_PER_MC` consecutive edges (24 by default). A shorter pulse has no effect. `sys_rst_o` falls at the first edge where `ext_rst_i` is sampled low.
- R8: A single-cycle `int_rst_req_i` pulse drives `sys_rst_o` high from the edge that samples it, for exactly `INT_RST_MC*CLKS_PER_MC` cycles (36 by default).
- R9: A system reset clears the register to 0x00 and returns `mode_o` to RUN.
- R10: During power-down, `osc_en_o` rises one edge after `ext_rst_i` or `int_rst_req_i` is sampled high. `osc_en_o` is 1 whenever `sys_rst_o` is 1.
- R11: `lvd_en_o` is 1 in every state, power-down included.
- R12: A register write that hits in the same cycle as `irq_i` takes effect, and the interrupt's clearing of bit 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| sfr_wr_i | input | 1 | SFR bus write strobe |
| sfr_addr_i | input | ADDR_W | SFR bus address |
| sfr_wdata_i | input | DATA_W | SFR bus write data |
| irq_i | input | 1 | Enabled interrupt request |
| ext_rst_i | input | 1 | External reset request (synchronous to clk) |
| int_rst_req_i | input | 1 | Internal reset request |
| ctl_reg_o | output | DATA_W | Current control register value |
| sys_rst_o | output | 1 | Registered system reset |
| cpu_clk_en_o | output | 1 | CPU core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| lvd_en_o | output | 1 | Low-voltage detector enable |
| mode_o | output | 2 | Mode: 0 RUN, 1 IDLE, 2 PDOWN |

## Verification
Directed sequences cover the state changes in turn:
- register writes at a foreign address and at the register's own address;
- idle entry, and the interrupt wake from idle;
- a write that collides with an interrupt;
- a write that sets both mode bits;
- interrupts and writes arriving while powered down.

These sequences separate the hardware clearing of the idle bit from software writes. They also show that power-down is left only through a reset. Reset stimulus uses an external pulse one cycle short of the qualifying length, then one long enough to qualify, then an internal pulse. This pins down the exact edge where the reset rises and falls and the cycle when the oscillator enable returns. A seeded random mix of writes, address misses and interrupts, with an internal reset after every power-down, is compared against a bench model of the register and mode.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pwr_mode_e;

  localparam int BIT_IDLE = 0;
  localparam int BIT_PD   = 1;
endpackage

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h87
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              sys_rst_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irq_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q;
  logic [DATA_W-1:0] wdata_fix;
  logic              wr_hit;

  // power-down locks the register against software until a reset
  assign wr_hit = wr_i && (addr_i == REG_ADDR) && !q[BIT_PD];

  always_comb begin
    wdata_fix = wdata_i;
    if (wdata_i[BIT_PD]) wdata_fix[BIT_IDLE] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst_i || sys_rst_i) begin
      q <= '0;
    end else if (wr_hit) begin
      q <= wdata_fix;
    end else if (irq_i && q[BIT_IDLE]) begin
      q[BIT_IDLE] <= 1'b0;
    end
  end

  assign q_o = q;

  // R4
  idle_wake_chk: assert property (@(posedge clk) disable iff (rst_i)
    (q[BIT_IDLE] && irq_i && !wr_hit && !sys_rst_i) |=> !q[BIT_IDLE]);

  // R6
  pd_hold_chk: assert property (@(posedge clk) disable iff (rst_i)
    (q[BIT_PD] && !sys_rst_i) |=> (q[BIT_PD] && $stable(q)));

  // R5
  mode_excl_chk: assert property (@(posedge clk) disable iff (rst_i)
    !(q[BIT_IDLE] && q[BIT_PD]));
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq #(
  parameter int CLKS_PER_MC = 12,
  parameter int EXT_RST_MC  = 2,
  parameter int INT_RST_MC  = 3
) (
  input  logic clk,
  input  logic rst_i,
  input  logic ext_rst_i,
  input  logic int_rst_req_i,
  output logic sys_rst_o
);
  localparam int EXT_LEN = CLKS_PER_MC * EXT_RST_MC;
  localparam int INT_LEN = CLKS_PER_MC * INT_RST_MC;
  localparam int EW      = $clog2(EXT_LEN + 1);
  localparam int IW      = $clog2(INT_LEN + 1);

  logic [EW-1:0] ext_cnt;
  logic [IW-1:0] int_cnt;
  logic [IW-1:0] int_nxt;
  logic          ext_term;
  logic          rst_q;

  assign ext_term = ext_rst_i && (ext_cnt >= EW'(EXT_LEN - 1));

  always_comb begin
    if (int_cnt != '0)          int_nxt = int_cnt - 1'b1;
    else if (int_rst_req_i)     int_nxt = IW'(INT_LEN);
    else                        int_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      ext_cnt <= '0;
      int_cnt <= '0;
      rst_q   <= 1'b1;
    end else begin
      if (!ext_rst_i)                    ext_cnt <= '0;
      else if (ext_cnt != EW'(EXT_LEN))  ext_cnt <= ext_cnt + 1'b1;
      int_cnt <= int_nxt;
      rst_q   <= ext_term || (int_nxt != '0);
    end
  end

  assign sys_rst_o = rst_q;

  // R7
  ext_cause_chk: assert property (@(posedge clk) disable iff (rst_i)
    ($rose(rst_q) && (int_cnt == '0)) |-> $past(ext_rst_i));

  // R8
  int_start_chk: assert property (@(posedge clk) disable iff (rst_i)
    (int_rst_req_i && !rst_q) |=> rst_q);
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_i,
  input  logic      idle_i,
  input  logic      pd_i,
  input  logic      ext_rst_i,
  input  logic      int_rst_req_i,
  input  logic      sys_rst_i,
  output logic      cpu_en_o,
  output logic      per_en_o,
  output logic      osc_en_o,
  output pwr_mode_e mode_o
);
  logic      cpu_en_q, per_en_q, osc_en_q;
  pwr_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      cpu_en_q <= 1'b1;
      per_en_q <= 1'b1;
      osc_en_q <= 1'b1;
      mode_q   <= MODE_RUN;
    end else begin
      cpu_en_q <= !(idle_i || pd_i);
      per_en_q <= !pd_i;
      // any reset cause wakes the oscillator before the reset qualifies
      osc_en_q <= !pd_i || ext_rst_i || int_rst_req_i || sys_rst_i;
      if (pd_i)        mode_q <= MODE_PDOWN;
      else if (idle_i) mode_q <= MODE_IDLE;
      else             mode_q <= MODE_RUN;
    end
  end

  assign cpu_en_o = cpu_en_q;
  assign per_en_o = per_en_q;
  assign osc_en_o = osc_en_q;
  assign mode_o   = mode_q;

  // R3
  idle_gate_chk: assert property (@(posedge clk) disable iff (rst_i)
    (mode_q == MODE_IDLE) |-> (!cpu_en_q && per_en_q && osc_en_q));

  // R5
  pd_gate_chk: assert property (@(posedge clk) disable iff (rst_i)
    (mode_q == MODE_PDOWN) |-> (!cpu_en_q && !per_en_q));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h87,
  parameter int CLKS_PER_MC = 12,
  parameter int EXT_RST_MC  = 2,
  parameter int INT_RST_MC  = 3
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              sfr_wr_i,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic [DATA_W-1:0] sfr_wdata_i,
  input  logic              irq_i,
  input  logic              ext_rst_i,
  input  logic              int_rst_req_i,
  output logic [DATA_W-1:0] ctl_reg_o,
  output logic              sys_rst_o,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              osc_en_o,
  output logic              lvd_en_o,
  output logic [1:0]        mode_o
);
  logic [DATA_W-1:0] ctl_q;
  logic              sys_rst;
  pwr_mode_e         mode;

  pwr_rst_seq #(
    .CLKS_PER_MC(CLKS_PER_MC),
    .EXT_RST_MC (EXT_RST_MC),
    .INT_RST_MC (INT_RST_MC)
  ) u_rst_seq (
    .clk          (clk),
    .rst_i        (rst_i),
    .ext_rst_i    (ext_rst_i),
    .int_rst_req_i(int_rst_req_i),
    .sys_rst_o    (sys_rst)
  );

  pwr_ctl_reg #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_ADDR(REG_ADDR)
  ) u_ctl_reg (
    .clk      (clk),
    .rst_i    (rst_i),
    .sys_rst_i(sys_rst),
    .wr_i     (sfr_wr_i),
    .addr_i   (sfr_addr_i),
    .wdata_i  (sfr_wdata_i),
    .irq_i    (irq_i),
    .q_o      (ctl_q)
  );

  pwr_clk_gate u_clk_gate (
    .clk          (clk),
    .rst_i        (rst_i),
    .idle_i       (ctl_q[BIT_IDLE]),
    .pd_i         (ctl_q[BIT_PD]),
    .ext_rst_i    (ext_rst_i),
    .int_rst_req_i(int_rst_req_i),
    .sys_rst_i    (sys_rst),
    .cpu_en_o     (cpu_clk_en_o),
    .per_en_o     (per_clk_en_o),
    .osc_en_o     (osc_en_o),
    .mode_o       (mode)
  );

  assign ctl_reg_o = ctl_q;
  assign sys_rst_o = sys_rst;
  assign mode_o    = mode;
  assign lvd_en_o  = 1'b1;

  // R10
  osc_in_rst_chk: assert property (@(posedge clk) disable iff (rst_i)
    sys_rst |-> osc_en_o);

  // R9
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst_i)
    sys_rst |=> (ctl_q == '0));
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
  localparam logic [7:0] ADDR = 8'h87;

  logic       clk = 1'b0;
  logic       rst_i = 1'b1;
  logic       sfr_wr_i = 1'b0;
  logic [7:0] sfr_addr_i = '0;
  logic [7:0] sfr_wdata_i = '0;
  logic       irq_i = 1'b0;
  logic       ext_rst_i = 1'b0;
  logic       int_rst_req_i = 1'b0;
  logic [7:0] ctl_reg_o;
  logic       sys_rst_o, cpu_clk_en_o, per_clk_en_o, osc_en_o, lvd_en_o;
  logic [1:0] mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst_i(rst_i), .sfr_wr_i(sfr_wr_i), .sfr_addr_i(sfr_addr_i),
    .sfr_wdata_i(sfr_wdata_i), .irq_i(irq_i), .ext_rst_i(ext_rst_i),
    .int_rst_req_i(int_rst_req_i), .ctl_reg_o(ctl_reg_o), .sys_rst_o(sys_rst_o),
    .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o), .osc_en_o(osc_en_o),
    .lvd_en_o(lvd_en_o), .mode_o(mode_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_next(input logic [7:0] q, input bit wr,
                                            input logic [7:0] a, input logic [7:0] d,
                                            input bit irq);
    logic [7:0] n = q;
    if (wr && a == ADDR && !q[1]) begin
      n = d;
      if (d[1]) n[0] = 1'b0;
    end else if (irq && q[0]) begin
      n[0] = 1'b0;
    end
    return n;
  endfunction

  function automatic logic [1:0] model_mode(input logic [7:0] q);
    if (q[1]) return 2'd2;
    if (q[0]) return 2'd1;
    return 2'd0;
  endfunction

  // drives one cycle from a negedge; returns at the next negedge with inputs cleared
  task automatic cyc(input bit wr, input logic [7:0] a, input logic [7:0] d, input bit irq);
    sfr_wr_i = wr; sfr_addr_i = a; sfr_wdata_i = d; irq_i = irq;
    @(negedge clk);
    sfr_wr_i = 1'b0; irq_i = 1'b0;
  endtask

  task automatic int_reset(output int len);
    int_rst_req_i = 1'b1;
    @(negedge clk);
    int_rst_req_i = 1'b0;
    len = 0;
    while (sys_rst_o && len < 100) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_q;
    int len;
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    chk("R1 sys_rst in reset", sys_rst_o, 1);
    rst_i = 1'b0;
    @(negedge clk);
    chk("R1 reg", ctl_reg_o, 8'h00);
    chk("R1 mode", mode_o, 0);
    chk("R1 enables", {cpu_clk_en_o, per_clk_en_o, osc_en_o}, 3'b111);
    chk("R1 sys_rst released", sys_rst_o, 0);
    chk("R11 lvd run", lvd_en_o, 1);

    // R2 address decode
    cyc(1, 8'h86, 8'hA5, 0);
    chk("R2 foreign addr ignored", ctl_reg_o, 8'h00);
    cyc(1, ADDR, 8'hE0, 0);
    chk("R2 write loads byte", ctl_reg_o, 8'hE0);

    // R3 idle entry
    cyc(1, ADDR, 8'hE1, 0);
    chk("R3 idle bit", ctl_reg_o, 8'hE1);
    @(negedge clk);
    chk("R3 mode idle", mode_o, 1);
    chk("R3 enables idle", {cpu_clk_en_o, per_clk_en_o, osc_en_o}, 3'b011);

    // R4 interrupt wake
    cyc(0, 8'h00, 8'h00, 1);
    chk("R4 idle cleared, others kept", ctl_reg_o, 8'hE0);
    @(negedge clk);
    chk("R4 mode run", mode_o, 0);
    chk("R4 cpu clock back", cpu_clk_en_o, 1);

    // R12 write beats interrupt
    cyc(1, ADDR, 8'h01, 1);
    chk("R12 write wins over irq", ctl_reg_o, 8'h01);
    cyc(0, 8'h00, 8'h00, 1);
    chk("R4 second wake", ctl_reg_o, 8'h00);

    // R5 power-down priority
    cyc(1, ADDR, 8'h03, 0);
    chk("R5 pd wins over idle", ctl_reg_o, 8'h02);
    @(negedge clk);
    chk("R5 mode pdown", mode_o, 2);
    chk("R5 enables off", {cpu_clk_en_o, per_clk_en_o, osc_en_o}, 3'b000);
    chk("R11 lvd in pdown", lvd_en_o, 1);

    // R6 nothing leaves power-down but reset
    cyc(0, 8'h00, 8'h00, 1);
    cyc(1, ADDR, 8'h00, 0);
    @(negedge clk);
    chk("R6 reg locked", ctl_reg_o, 8'h02);
    chk("R6 mode stays pdown", mode_o, 2);

    // R7 short external pulse, R10 oscillator wake
    ext_rst_i = 1'b1;
    @(negedge clk);
    chk("R10 osc wakes on ext", osc_en_o, 1);
    repeat (22) @(negedge clk);
    chk("R7 23 cycles not enough", sys_rst_o, 0);
    ext_rst_i = 1'b0;
    @(negedge clk);
    chk("R7 short pulse no reset", sys_rst_o, 0);
    chk("R7 short pulse reg kept", ctl_reg_o, 8'h02);
    chk("R10 osc off after short pulse", osc_en_o, 0);

    // R7 qualifying pulse
    ext_rst_i = 1'b1;
    repeat (23) @(negedge clk);
    chk("R7 before threshold", sys_rst_o, 0);
    @(negedge clk);
    chk("R7 rises at 24th edge", sys_rst_o, 1);
    chk("R10 osc on in reset", osc_en_o, 1);
    repeat (4) @(negedge clk);
    chk("R7 held while input high", sys_rst_o, 1);
    ext_rst_i = 1'b0;
    @(negedge clk);
    chk("R7 falls on release", sys_rst_o, 0);
    chk("R9 reg cleared", ctl_reg_o, 8'h00);
    chk("R9 mode run", mode_o, 0);

    // R8 internal reset length, R9 clear
    cyc(1, ADDR, 8'hC2, 0);
    @(negedge clk);
    int_reset(len);
    chk("R8 internal length", len, 36);
    chk("R9 reg cleared by internal", ctl_reg_o, 8'h00);
    chk("R9 mode run after internal", mode_o, 0);

    // random mix against the model
    exp_q = 8'h00;
    for (int i = 0; i < 300; i++) begin
      int op;
      bit wr, irq;
      logic [7:0] a, d;
      op  = int'($urandom % 8);
      wr  = (op < 5) || (op == 7);
      irq = (op >= 5);
      a   = ($urandom % 2) ? ADDR : 8'($urandom);
      d   = 8'($urandom);
      cyc(wr, a, d, irq);
      exp_q = model_next(exp_q, wr, a, d, irq);
      chk("R2 random reg", ctl_reg_o, exp_q);
      @(negedge clk);
      chk("R3 random mode", mode_o, model_mode(exp_q));
      if (exp_q[1]) begin
        int_reset(len);
        chk("R8 random internal length", len, 36);
        exp_q = 8'h00;
        chk("R9 random clear", ctl_reg_o, exp_q);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule